// File: doc/BRIEF.md
# Privileged Scratch Register Access Gate

This block holds one 64-bit scratch register for supervisor software. It sits behind the decode port for system instructions. The hardware never interprets the stored value. Each request carries five selector fields, a read strobe and a write strobe, a narrow-view flag, the current privilege level (0 to 3) and six hypervisor configuration bits. The gate resolves each request to one of three outcomes: OK, UNDEFINED or TRAP. When the outcome is TRAP, it also reports the target level and the syndrome class.

The narrow view reaches only the low half of the register. A narrow write keeps the upper half unchanged. A narrow read returns the low half with the upper bits zero-extended.

When both strobes are high in the same cycle, the request is handled as a write and no data is returned. Reads resolve combinationally in the cycle of the request. A permitted write lands on the next rising clock edge.

Top module: `sysreg_scratch_gate`

## Requirements
- R1: During and after reset, with no request present, `status` is 2'b00 (OK), `hit` is low, `rd_data` is zero and `trap_ec` is zero. The stored value after reset is unspecified.
- R2: A request selects the register only when op0=3, op1=0, crn=13, crm=0 and op2=4. Any other selector leaves `hit` low and `status` at 2'b00, and changes nothing.
- R3: Any selected read or write at level 0 gives `status` 2'b01 (UNDEFINED), returns zero and leaves the register unchanged.
- R4: At level 1, a request traps only when all four conditions hold: `hyp_l2_on` is 1, `hyp_l2_wide` is 1, either `hyp_l3_here` is 0 or `hyp_l3_fgt` is 1, and the trap bit for the request's direction is 1.
- R5: The trap bit for reads (`hyp_rd_trap`) and the trap bit for writes (`hyp_wr_trap`) each act only on their own direction.
- R6: A trapped request gives `status` 2'b10 (TRAP), `trap_lvl` 2 and `trap_ec` 0x18. It returns zero data and leaves the register unchanged.
- R7: An OK read returns all 64 bits in the same cycle. An OK wide write stores all 64 bits of `wr_data` at the next rising edge. Requests at levels 2 and 3 never trap.
- R8: An OK narrow write changes only bits [31:0]. An OK narrow read returns bits [31:0] with the upper 32 bits at zero.
- R9: Whenever neither strobe is high, `status` is 2'b00, `trap_lvl` is 0 and `trap_ec` is 0, whatever the configuration inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| sel_op0 | input | 2 | Selector field op0 |
| sel_op1 | input | 3 | Selector field op1 |
| sel_crn | input | 4 | Selector field CRn |
| sel_crm | input | 4 | Selector field CRm |
| sel_op2 | input | 3 | Selector field op2 |
| rd_req | input | 1 | Read strobe |
| wr_req | input | 1 | Write strobe (takes precedence over read) |
| narrow | input | 1 | Access goes through the 32-bit low-half view |
| wr_data | input | 64 | Source value for writes |
| cur_lvl | input | 2 | Current privilege level |
| hyp_l2_on | input | 1 | Level 2 enabled |
| hyp_l2_wide | input | 1 | Level 2 runs in 64-bit mode |
| hyp_l3_here | input | 1 | Level 3 implemented |
| hyp_l3_fgt | input | 1 | Level 3 permits fine-grained traps |
| hyp_rd_trap | input | 1 | Trap level-1 reads to level 2 |
| hyp_wr_trap | input | 1 | Trap level-1 writes to level 2 |
| rd_data | output | 64 | Read result, zero unless the read resolves OK |
| hit | output | 1 | Request selects this register |
| status | output | 2 | 00 OK, 01 UNDEFINED, 10 TRAP |
| trap_lvl | output | 2 | Target level of a trap, otherwise 0 |
| trap_ec | output | 6 | Syndrome class of a trap, otherwise 0 |

## Verification
The bench targets each term of the level-1 trap condition one at a time. It covers level 2 running in 32-bit mode, level 3 absent with its enable clear, and level 3 present with its enable clear. A design that dropped or inverted any term would trap where OK is expected, or the reverse. It crosses the read and write trap bits so that a design that shared one bit between directions fails. It follows a trapped write with a read of the old value to expose a leaking write enable. It also checks that a narrow write keeps the upper half, which a design that stored the full word would break.

// File: rtl/sysreg_gate_pkg.sv
package sysreg_gate_pkg;

   typedef enum logic [1:0] {
      ST_OK    = 2'b00,
      ST_UNDEF = 2'b01,
      ST_TRAP  = 2'b10
   } acc_status_e;

   typedef struct packed {
      logic [1:0] op0;
      logic [2:0] op1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] op2;
   } sel_t;

   typedef struct packed {
      logic l2_on;
      logic l2_wide;
      logic l3_here;
      logic l3_fgt;
      logic rd_trap;
      logic wr_trap;
   } hyp_cfg_t;

endpackage

// File: rtl/scratch_sel_decode.sv
module scratch_sel_decode
   import sysreg_gate_pkg::*;
#(
   parameter logic [1:0] M_OP0 = 2'b11,
   parameter logic [2:0] M_OP1 = 3'b000,
   parameter logic [3:0] M_CRN = 4'b1101,
   parameter logic [3:0] M_CRM = 4'b0000,
   parameter logic [2:0] M_OP2 = 3'b100
) (
   input  sel_t sel,
   input  logic rd_req,
   input  logic wr_req,
   output logic hit,
   output logic is_read,
   output logic is_write
);
   localparam sel_t MATCH = '{op0: M_OP0, op1: M_OP1, crn: M_CRN, crm: M_CRM, op2: M_OP2};

   logic sel_match;

   always_comb begin
      sel_match = (sel == MATCH);
      hit       = sel_match & (rd_req | wr_req);
      is_write  = hit & wr_req;
      is_read   = hit & rd_req & ~wr_req;
   end
endmodule

// File: rtl/scratch_priv_check.sv
module scratch_priv_check
   import sysreg_gate_pkg::*;
#(
   parameter bit          HAS_FGT = 1'b1,
   parameter int          EC_W    = 6,
   parameter logic [EC_W-1:0] TRAP_EC = EC_W'(8'h18),
   parameter logic [1:0]  TRAP_LVL = 2'd2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            is_read,
   input  logic            is_write,
   input  logic [1:0]      lvl,
   input  hyp_cfg_t        cfg,
   output acc_status_e     status,
   output logic [1:0]      trap_lvl,
   output logic [EC_W-1:0] trap_ec
);
   localparam logic [1:0] LVL_USER = 2'd0;
   localparam logic [1:0] LVL_SUP  = 2'd1;

   logic any_req;
   logic fgt_fire;

   generate
      if (EC_W < 5) begin : g_bad_ec
         $error("scratch_priv_check: EC_W too narrow for the syndrome class");
      end
      if (HAS_FGT) begin : g_fgt
         logic gate_open;
         logic dir_bit;
         always_comb begin
            gate_open = cfg.l2_on & cfg.l2_wide & (~cfg.l3_here | cfg.l3_fgt);
            dir_bit   = (is_read & cfg.rd_trap) | (is_write & cfg.wr_trap);
            fgt_fire  = gate_open & dir_bit;
         end
      end else begin : g_no_fgt
         assign fgt_fire = 1'b0;
      end
   endgenerate

   always_comb begin
      any_req  = is_read | is_write;
      status   = ST_OK;
      trap_lvl = 2'd0;
      trap_ec  = '0;
      if (any_req) begin
         if (lvl == LVL_USER) begin
            status = ST_UNDEF;
         end else if (lvl == LVL_SUP && fgt_fire) begin
            status   = ST_TRAP;
            trap_lvl = TRAP_LVL;
            trap_ec  = TRAP_EC;
         end
      end
   end

   assert_user_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (any_req && lvl == LVL_USER) |-> status == ST_UNDEF);

   assert_high_lvl_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[1]) |-> status != ST_TRAP);

   assert_dir_indep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && !cfg.rd_trap) |-> status != ST_TRAP);

endmodule

// File: rtl/scratch_store.sv
module scratch_store #(
   parameter int                DATA_W  = 64,
   parameter int                ALIAS_W = 32,
   parameter logic [DATA_W-1:0] POISON  = {(DATA_W/4){4'hD}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_wide,
   input  logic              wr_narrow,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);
   localparam int HI_W = DATA_W - ALIAS_W;

   generate
      if (ALIAS_W < 1 || ALIAS_W > DATA_W) begin : g_bad_alias
         $error("scratch_store: ALIAS_W must lie in 1..DATA_W");
      end

      logic [ALIAS_W-1:0] lo_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  lo_q <= POISON[ALIAS_W-1:0];
         else if (wr_wide | wr_narrow) lo_q <= wr_data[ALIAS_W-1:0];
      end

      if (HI_W > 0) begin : g_split
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hi_q <= POISON[DATA_W-1:ALIAS_W];
            else if (wr_wide) hi_q <= wr_data[DATA_W-1:ALIAS_W];
         end
         assign q = {hi_q, lo_q};

         assert_alias_high_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_narrow && !wr_wide) |=> q[DATA_W-1:ALIAS_W] == $past(q[DATA_W-1:ALIAS_W]));
      end else begin : g_flat
         assign q = lo_q;
      end
   endgenerate

   assert_alias_low_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_narrow) |=> q[ALIAS_W-1:0] == $past(wr_data[ALIAS_W-1:0]));

   assert_one_write_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_wide && wr_narrow));

endmodule

// File: rtl/sysreg_scratch_gate.sv
module sysreg_scratch_gate
   import sysreg_gate_pkg::*;
#(
   parameter int                DATA_W  = 64,
   parameter int                ALIAS_W = 32,
   parameter int                EC_W    = 6,
   parameter bit                HAS_FGT = 1'b1,
   parameter logic [EC_W-1:0]   TRAP_EC = 6'h18,
   parameter logic [DATA_W-1:0] POISON  = {(DATA_W/4){4'hD}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        sel_op0,
   input  logic [2:0]        sel_op1,
   input  logic [3:0]        sel_crn,
   input  logic [3:0]        sel_crm,
   input  logic [2:0]        sel_op2,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic              narrow,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        cur_lvl,
   input  logic              hyp_l2_on,
   input  logic              hyp_l2_wide,
   input  logic              hyp_l3_here,
   input  logic              hyp_l3_fgt,
   input  logic              hyp_rd_trap,
   input  logic              hyp_wr_trap,
   output logic [DATA_W-1:0] rd_data,
   output logic              hit,
   output logic [1:0]        status,
   output logic [1:0]        trap_lvl,
   output logic [EC_W-1:0]   trap_ec
);
   localparam int HI_W = DATA_W - ALIAS_W;

   sel_t        sel;
   hyp_cfg_t    cfg;
   logic        is_read, is_write;
   acc_status_e st;
   logic        granted;
   logic        wr_wide, wr_narrow;
   logic [DATA_W-1:0] q;

   assign sel = '{op0: sel_op0, op1: sel_op1, crn: sel_crn, crm: sel_crm, op2: sel_op2};
   assign cfg = '{l2_on: hyp_l2_on, l2_wide: hyp_l2_wide, l3_here: hyp_l3_here,
                  l3_fgt: hyp_l3_fgt, rd_trap: hyp_rd_trap, wr_trap: hyp_wr_trap};

   scratch_sel_decode u_dec (
      .sel      (sel),
      .rd_req   (rd_req),
      .wr_req   (wr_req),
      .hit      (hit),
      .is_read  (is_read),
      .is_write (is_write)
   );

   scratch_priv_check #(
      .HAS_FGT (HAS_FGT),
      .EC_W    (EC_W),
      .TRAP_EC (TRAP_EC)
   ) u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_read  (is_read),
      .is_write (is_write),
      .lvl      (cur_lvl),
      .cfg      (cfg),
      .status   (st),
      .trap_lvl (trap_lvl),
      .trap_ec  (trap_ec)
   );

   assign granted   = (st == ST_OK);
   assign wr_wide   = is_write & granted & ~narrow;
   assign wr_narrow = is_write & granted & narrow;
   assign status    = st;

   scratch_store #(
      .DATA_W  (DATA_W),
      .ALIAS_W (ALIAS_W),
      .POISON  (POISON)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_wide   (wr_wide),
      .wr_narrow (wr_narrow),
      .wr_data   (wr_data),
      .q         (q)
   );

   generate
      if (HI_W > 0) begin : g_rd_split
         always_comb begin
            rd_data = '0;
            if (is_read && granted) rd_data = narrow ? {{HI_W{1'b0}}, q[ALIAS_W-1:0]} : q;
         end
      end else begin : g_rd_flat
         always_comb begin
            rd_data = '0;
            if (is_read && granted) rd_data = q;
         end
      end
   endgenerate

   assert_trap_no_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_write && st != ST_OK) |=> q == $past(q));

   assert_trap_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_TRAP) |-> (trap_lvl == 2'd2 && trap_ec == TRAP_EC && rd_data == '0));

   assert_wide_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_write && status == ST_OK && !narrow) |=> q == $past(wr_data));

   assert_idle_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req && !wr_req) |-> (status == ST_OK && trap_lvl == 2'd0 && trap_ec == '0));

   assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit) |=> q == $past(q));

endmodule

// File: tb/sysreg_scratch_gate_tb.sv
module sysreg_scratch_gate_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0]  sel_op0;
   logic [2:0]  sel_op1;
   logic [3:0]  sel_crn, sel_crm;
   logic [2:0]  sel_op2;
   logic        rd_req, wr_req, narrow;
   logic [63:0] wr_data;
   logic [1:0]  cur_lvl;
   logic [5:0]  cfg;
   logic [63:0] rd_data;
   logic        hit;
   logic [1:0]  status, trap_lvl;
   logic [5:0]  trap_ec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   sysreg_scratch_gate u_dut (
      .clk(clk), .rst_n(rst_n),
      .sel_op0(sel_op0), .sel_op1(sel_op1), .sel_crn(sel_crn), .sel_crm(sel_crm), .sel_op2(sel_op2),
      .rd_req(rd_req), .wr_req(wr_req), .narrow(narrow), .wr_data(wr_data), .cur_lvl(cur_lvl),
      .hyp_l2_on(cfg[5]), .hyp_l2_wide(cfg[4]), .hyp_l3_here(cfg[3]), .hyp_l3_fgt(cfg[2]),
      .hyp_rd_trap(cfg[1]), .hyp_wr_trap(cfg[0]),
      .rd_data(rd_data), .hit(hit), .status(status), .trap_lvl(trap_lvl), .trap_ec(trap_ec)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [1:0]  lvl;
      logic        rd;
      logic        wr;
      logic        nar;
      logic [5:0]  cfg;   // l2_on l2_wide l3_here l3_fgt rd_trap wr_trap
      logic [63:0] data;
      logic [1:0]  exp_st;
      logic [63:0] exp_rd;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{4'd7, 2'd2, 1'b0, 1'b1, 1'b0, 6'b000000, 64'h1111_2222_3333_4444, 2'b00, 64'h0},                    // R7 level 2 write
      '{4'd7, 2'd2, 1'b1, 1'b0, 1'b0, 6'b000000, 64'h0, 2'b00, 64'h1111_2222_3333_4444},                    // R7 read back
      '{4'd3, 2'd0, 1'b1, 1'b0, 1'b0, 6'b000000, 64'h0, 2'b01, 64'h0},                                      // R3 user read
      '{4'd3, 2'd0, 1'b0, 1'b1, 1'b0, 6'b000000, 64'hBAD0_BAD0_BAD0_BAD0, 2'b01, 64'h0},                    // R3 user write
      '{4'd3, 2'd3, 1'b1, 1'b0, 1'b0, 6'b000000, 64'h0, 2'b00, 64'h1111_2222_3333_4444},                    // R3 unchanged
      '{4'd6, 2'd1, 1'b0, 1'b1, 1'b0, 6'b111101, 64'hA5A5_A5A5_5A5A_5A5A, 2'b10, 64'h0},                    // R6 write trap
      '{4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 6'b111101, 64'h0, 2'b00, 64'h1111_2222_3333_4444},                    // R5 read free, R6 no update
      '{4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 6'b111110, 64'h0, 2'b10, 64'h0},                                      // R5 read trap
      '{4'd5, 2'd1, 1'b0, 1'b1, 1'b0, 6'b111110, 64'hA5A5_A5A5_5A5A_5A5A, 2'b00, 64'h0},                    // R5 write free
      '{4'd7, 2'd1, 1'b1, 1'b0, 1'b0, 6'b000000, 64'h0, 2'b00, 64'hA5A5_A5A5_5A5A_5A5A},                    // R7 level 1 read
      '{4'd4, 2'd1, 1'b0, 1'b1, 1'b0, 6'b011111, 64'h0123_4567_89AB_CDEF, 2'b00, 64'h0},                    // R4 level 2 off
      '{4'd4, 2'd1, 1'b1, 1'b0, 1'b0, 6'b101111, 64'h0, 2'b00, 64'h0123_4567_89AB_CDEF},                    // R4 level 2 narrow mode
      '{4'd4, 2'd1, 1'b1, 1'b0, 1'b0, 6'b110011, 64'h0, 2'b10, 64'h0},                                      // R4 level 3 absent
      '{4'd4, 2'd1, 1'b1, 1'b0, 1'b0, 6'b111011, 64'h0, 2'b00, 64'h0123_4567_89AB_CDEF},                    // R4 level 3 enable clear
      '{4'd8, 2'd2, 1'b0, 1'b1, 1'b1, 6'b111111, 64'hFFFF_FFFF_DEAD_BEEF, 2'b00, 64'h0},                    // R8 narrow write, R7 no trap at level 2
      '{4'd8, 2'd3, 1'b1, 1'b0, 1'b0, 6'b111111, 64'h0, 2'b00, 64'h0123_4567_DEAD_BEEF},                    // R8 upper half kept
      '{4'd8, 2'd1, 1'b1, 1'b0, 1'b1, 6'b000000, 64'h0, 2'b00, 64'h0000_0000_DEAD_BEEF}                     // R8 narrow read
   };

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_sel_ok();
      sel_op0 = 2'b11; sel_op1 = 3'b000; sel_crn = 4'b1101; sel_crm = 4'b0000; sel_op2 = 3'b100;
   endtask

   task automatic idle();
      rd_req = 1'b0; wr_req = 1'b0; narrow = 1'b0; wr_data = '0;
   endtask

   initial begin
      set_sel_ok();
      idle();
      cur_lvl = 2'd1;
      cfg     = 6'b111111;
      #1;
      // R1: outputs quiet during reset
      chk(status == 2'b00 && hit == 1'b0 && rd_data == '0 && trap_ec == '0, "R1 in reset",
          {58'b0, status, hit, 3'b0}, 64'h0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk(status == 2'b00 && hit == 1'b0 && rd_data == '0, "R1 after reset",
          {62'b0, status}, 64'h0);
      // R9: idle with every trap bit set at level 1
      chk(status == 2'b00 && trap_lvl == 2'd0 && trap_ec == '0, "R9 idle",
          {56'b0, trap_ec, trap_lvl}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cur_lvl = TBL[i].lvl; rd_req = TBL[i].rd; wr_req = TBL[i].wr;
         narrow = TBL[i].nar; cfg = TBL[i].cfg; wr_data = TBL[i].data;
         #1;
         chk(status == TBL[i].exp_st, $sformatf("R%0d row %0d status", TBL[i].req, i),
             {62'b0, status}, {62'b0, TBL[i].exp_st});
         chk(rd_data == TBL[i].exp_rd, $sformatf("R%0d row %0d data", TBL[i].req, i),
             rd_data, TBL[i].exp_rd);
         if (TBL[i].exp_st == 2'b10)
            chk(trap_lvl == 2'd2 && trap_ec == 6'h18, $sformatf("R6 row %0d trap info", i),
                {56'b0, trap_ec, trap_lvl}, {56'b0, 6'h18, 2'd2});
      end

      // R2: mismatched selector at level 0 write: no hit, OK, no update
      @(negedge clk);
      sel_op2 = 3'b011; cur_lvl = 2'd0; rd_req = 1'b0; wr_req = 1'b1; narrow = 1'b0;
      wr_data = 64'hCAFE_CAFE_CAFE_CAFE; cfg = 6'b000000;
      #1;
      chk(hit == 1'b0 && status == 2'b00, "R2 miss status", {62'b0, hit, status[0]}, 64'h0);
      @(negedge clk);
      set_sel_ok(); cur_lvl = 2'd2; rd_req = 1'b1; wr_req = 1'b0;
      #1;
      chk(rd_data == 64'h0123_4567_DEAD_BEEF, "R2 miss left value", rd_data, 64'h0123_4567_DEAD_BEEF);

      // R9: idle at level 0 with traps set
      @(negedge clk);
      idle(); cur_lvl = 2'd0; cfg = 6'b111111;
      #1;
      chk(status == 2'b00 && trap_lvl == 2'd0 && trap_ec == '0, "R9 idle user",
          {62'b0, status}, 64'h0);

      // R7: level 3 wide write lands, then level 1 read with read trap clear
      @(negedge clk);
      cur_lvl = 2'd3; wr_req = 1'b1; wr_data = 64'hFEDC_BA98_7654_3210; cfg = 6'b111111;
      #1;
      chk(status == 2'b00, "R7 level 3 write ok", {62'b0, status}, 64'h0);
      @(negedge clk);
      idle(); cur_lvl = 2'd1; rd_req = 1'b1; cfg = 6'b111101;
      #1;
      chk(rd_data == 64'hFEDC_BA98_7654_3210, "R7 level 3 write stored", rd_data, 64'hFEDC_BA98_7654_3210);

      @(negedge clk);
      idle();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule